// File: doc/BRIEF.md
# Fused Micro-Op Integer ALU

This block is a 64-bit integer execution unit for a core whose decoder merges pairs of simple instructions into one internal micro-op. Next to the ordinary add, subtract, shift and logic operations, it runs the merged operations. Each merged operation gives exactly the value that the original two-instruction sequence would leave in its destination register. Examples are a shift followed by an add, a zero-extend followed by a shift, a byte extract, a word add narrowed to a byte or a bit, and a logic operation reduced to its least significant bit.

A 6-bit operation code and two 64-bit operands enter together with a valid bit. The result is computed combinationally and captured in one output register on the rising clock edge. The valid bit is registered alongside it. An unused code produces zero.

Top module: `fused_alu`

## Requirements
- R1: Standard codes: 0 add, 1 sub (a-b), 2 shift left, 3 logical shift right, 4 arithmetic shift right (shift amount is src_b[5:0]), 5 and, 6 or, 7 xor, 8/9/10 return (src_a shifted left by 1/2/3) + src_b.
- R2: Codes 24, 25 and 26 return the low 32 bits of src_a, zero-extended and then shifted left by 1, 2 and 3. This equals a left shift by 32 followed by a logical right shift by 31, 30 and 29.
- R3: Code 27 returns bits 15:8 of src_a in the low byte, with every other bit zero.
- R4: Code 16 returns (src_a shifted left by 4) + src_b, modulo 2^64.
- R5: Codes 17, 18, 19 and 20 return (src_a logically shifted right by 29, 30, 31 and 32) + src_b, modulo 2^64.
- R6: Code 21 returns (src_a & 1) + src_b in 64 bits. Code 22 forms the same sum over the low 32 bits and sign-extends its bit 31 to 64 bits.
- R7: Code 32 forms the 32-bit sum of the low words of the operands, sign-extends it, and keeps only bits 7:0. Code 33 keeps only bit 0 of that sum. All other bits are zero.
- R8: Codes 40 to 45 return, in bit 0 only, the LSB of a&b, a|b, a^b, a&~b, a|~b and ~(a^b), in that order. Bits 63:1 are zero.
- R9: Code 28 returns (src_a with bits 7:0 cleared) | src_b.
- R10: Any code not listed above gives a zero result.
- R11: A value accepted with in_valid high appears on out_result at the next rising edge, and out_valid there equals the previous cycle's in_valid.
- R12: Synchronous active-high rst forces out_valid low on the next edge, but does not clear out_result. A valid input presented during reset still loads the result register.
- R13: While in_valid is low, out_result holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid bit |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op | input | 6 | Operation code |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 64 | Registered result |

## Verification
Reset and a valid input can arrive in the same cycle. They act on different registers: reset clears the valid bit, while the input still loads the result register. The bench first brings out_valid high. It then asserts reset together with a valid add of 5 and 7. On the following cycle it expects out_valid low and out_result equal to 12. Every merged operation is compared with a model that executes the two original instructions one after the other. The operands used are all ones, 0x8000_0000, 0x7FFF_FFFF, zero and random values.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OPC_ADD       = 6'd0;
  localparam logic [OP_W-1:0] OPC_SUB       = 6'd1;
  localparam logic [OP_W-1:0] OPC_SLL       = 6'd2;
  localparam logic [OP_W-1:0] OPC_SRL       = 6'd3;
  localparam logic [OP_W-1:0] OPC_SRA       = 6'd4;
  localparam logic [OP_W-1:0] OPC_AND       = 6'd5;
  localparam logic [OP_W-1:0] OPC_OR        = 6'd6;
  localparam logic [OP_W-1:0] OPC_XOR       = 6'd7;
  localparam logic [OP_W-1:0] OPC_SH1ADD    = 6'd8;
  localparam logic [OP_W-1:0] OPC_SH2ADD    = 6'd9;
  localparam logic [OP_W-1:0] OPC_SH3ADD    = 6'd10;
  localparam logic [OP_W-1:0] OPC_SH4ADD    = 6'd16;
  localparam logic [OP_W-1:0] OPC_SR29ADD   = 6'd17;
  localparam logic [OP_W-1:0] OPC_SR30ADD   = 6'd18;
  localparam logic [OP_W-1:0] OPC_SR31ADD   = 6'd19;
  localparam logic [OP_W-1:0] OPC_SR32ADD   = 6'd20;
  localparam logic [OP_W-1:0] OPC_ODDADD    = 6'd21;
  localparam logic [OP_W-1:0] OPC_ODDADDW   = 6'd22;
  localparam logic [OP_W-1:0] OPC_ZWSHL1    = 6'd24;
  localparam logic [OP_W-1:0] OPC_ZWSHL2    = 6'd25;
  localparam logic [OP_W-1:0] OPC_ZWSHL3    = 6'd26;
  localparam logic [OP_W-1:0] OPC_BYTE1     = 6'd27;
  localparam logic [OP_W-1:0] OPC_ORHI      = 6'd28;
  localparam logic [OP_W-1:0] OPC_ADDW_B8   = 6'd32;
  localparam logic [OP_W-1:0] OPC_ADDW_B1   = 6'd33;
  localparam logic [OP_W-1:0] OPC_AND_LSB   = 6'd40;
  localparam logic [OP_W-1:0] OPC_OR_LSB    = 6'd41;
  localparam logic [OP_W-1:0] OPC_XOR_LSB   = 6'd42;
  localparam logic [OP_W-1:0] OPC_ANDN_LSB  = 6'd43;
  localparam logic [OP_W-1:0] OPC_ORN_LSB   = 6'd44;
  localparam logic [OP_W-1:0] OPC_XNOR_LSB  = 6'd45;

  function automatic logic fa_is_lsb(input logic [OP_W-1:0] c);
    return (c >= OPC_AND_LSB) && (c <= OPC_XNOR_LSB);
  endfunction

  function automatic logic fa_is_defined(input logic [OP_W-1:0] c);
    logic d;
    case (c)
      OPC_ADD, OPC_SUB, OPC_SLL, OPC_SRL, OPC_SRA, OPC_AND, OPC_OR, OPC_XOR,
      OPC_SH1ADD, OPC_SH2ADD, OPC_SH3ADD, OPC_SH4ADD,
      OPC_SR29ADD, OPC_SR30ADD, OPC_SR31ADD, OPC_SR32ADD,
      OPC_ODDADD, OPC_ODDADDW, OPC_ZWSHL1, OPC_ZWSHL2, OPC_ZWSHL3,
      OPC_BYTE1, OPC_ORHI, OPC_ADDW_B8, OPC_ADDW_B1,
      OPC_AND_LSB, OPC_OR_LSB, OPC_XOR_LSB, OPC_ANDN_LSB, OPC_ORN_LSB,
      OPC_XNOR_LSB: d = 1'b1;
      default:      d = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/fa_arith.sv
module fa_arith
  import fa_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            hit
);
  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  logic [SHW-1:0]  amt;
  logic [HALF-1:0] wsum;
  logic [HALF-1:0] wodd;
  logic [XLEN-1:0] wsum_x;
  logic [XLEN-1:0] wodd_x;
  logic [XLEN-1:0] shl_add [1:4];
  logic [XLEN-1:0] shr_add [29:32];

  assign amt    = b[SHW-1:0];
  assign wsum   = a[HALF-1:0] + b[HALF-1:0];
  assign wodd   = {{(HALF-1){1'b0}}, a[0]} + b[HALF-1:0];
  assign wsum_x = {{HALF{wsum[HALF-1]}}, wsum};
  assign wodd_x = {{HALF{wodd[HALF-1]}}, wodd};

  for (genvar k = 1; k <= 4; k++) begin : g_shl
    assign shl_add[k] = (a << k) + b;
  end
  for (genvar k = 29; k <= 32; k++) begin : g_shr
    assign shr_add[k] = (a >> k) + b;
  end

  always_comb begin
    hit = 1'b1;
    res = '0;
    case (op)
      OPC_ADD:     res = a + b;
      OPC_SUB:     res = a - b;
      OPC_SLL:     res = a << amt;
      OPC_SRL:     res = a >> amt;
      OPC_SRA:     res = $signed(a) >>> amt;
      OPC_SH1ADD:  res = shl_add[1];
      OPC_SH2ADD:  res = shl_add[2];
      OPC_SH3ADD:  res = shl_add[3];
      OPC_SH4ADD:  res = shl_add[4];
      OPC_SR29ADD: res = shr_add[29];
      OPC_SR30ADD: res = shr_add[30];
      OPC_SR31ADD: res = shr_add[31];
      OPC_SR32ADD: res = shr_add[32];
      OPC_ODDADD:  res = {{(XLEN-1){1'b0}}, a[0]} + b;
      OPC_ODDADDW: res = wodd_x;
      OPC_ADDW_B8: res = {{(XLEN-8){1'b0}}, wsum_x[7:0]};
      OPC_ADDW_B1: res = {{(XLEN-1){1'b0}}, wsum_x[0]};
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/fa_logic.sv
module fa_logic
  import fa_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            hit
);
  localparam int HALF = XLEN / 2;
  localparam int BYTE = 8;

  logic [XLEN-1:0] l_and;
  logic [XLEN-1:0] l_or;
  logic [XLEN-1:0] l_xor;
  logic [XLEN-1:0] zword;
  logic [XLEN-1:0] zw_shl [1:3];

  assign l_and = a & b;
  assign l_or  = a | b;
  assign l_xor = a ^ b;
  assign zword = {{HALF{1'b0}}, a[HALF-1:0]};

  for (genvar k = 1; k <= 3; k++) begin : g_zw
    assign zw_shl[k] = zword << k;
  end

  always_comb begin
    hit = 1'b1;
    res = '0;
    case (op)
      OPC_AND:      res = l_and;
      OPC_OR:       res = l_or;
      OPC_XOR:      res = l_xor;
      OPC_ZWSHL1:   res = zw_shl[1];
      OPC_ZWSHL2:   res = zw_shl[2];
      OPC_ZWSHL3:   res = zw_shl[3];
      OPC_BYTE1:    res = {{(XLEN-BYTE){1'b0}}, a[2*BYTE-1:BYTE]};
      OPC_ORHI:     res = {a[XLEN-1:BYTE], {BYTE{1'b0}}} | b;
      OPC_AND_LSB:  res = {{(XLEN-1){1'b0}}, l_and[0]};
      OPC_OR_LSB:   res = {{(XLEN-1){1'b0}}, l_or[0]};
      OPC_XOR_LSB:  res = {{(XLEN-1){1'b0}}, l_xor[0]};
      OPC_ANDN_LSB: res = {{(XLEN-1){1'b0}}, a[0] & ~b[0]};
      OPC_ORN_LSB:  res = {{(XLEN-1){1'b0}}, a[0] | ~b[0]};
      OPC_XNOR_LSB: res = {{(XLEN-1){1'b0}}, ~l_xor[0]};
      default:      hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/fused_alu.sv
module fused_alu
  import fa_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  output logic              out_valid,
  output logic [XLEN-1:0]   out_result
);
  logic [XLEN-1:0] ar_res;
  logic [XLEN-1:0] lg_res;
  logic [XLEN-1:0] nxt;
  logic            ar_hit;
  logic            lg_hit;
  logic            vld_q = 1'b0;
  logic [XLEN-1:0] res_q = '0;

  fa_arith #(.XLEN(XLEN)) u_arith (
    .op(op), .a(src_a), .b(src_b), .res(ar_res), .hit(ar_hit)
  );

  fa_logic #(.XLEN(XLEN)) u_logic (
    .op(op), .a(src_a), .b(src_b), .res(lg_res), .hit(lg_hit)
  );

  always_comb begin
    if (ar_hit)      nxt = ar_res;
    else if (lg_hit) nxt = lg_res;
    else             nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= in_valid;
    if (in_valid) res_q <= nxt;
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !rst) |-> out_valid);

  // R11
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!in_valid) |-> !out_valid);

  // R13
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!in_valid) |-> $stable(out_result));

  // R8
  lsb_upper_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && fa_is_lsb(op)) |-> (out_result[XLEN-1:1] == '0));

  // R7
  narrow_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && (op == OPC_ADDW_B8)) |-> (out_result[XLEN-1:8] == '0));

  // R10
  undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !fa_is_defined(op)) |-> (out_result == '0));
endmodule

// File: tb/sim_fused_alu.sv
`timescale 1ns/1ps
module sim_fused_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [5:0]  op = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        out_valid;
  logic [63:0] out_result;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] vals [6];

  always #4 clk = ~clk;

  fused_alu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .out_result(out_result)
  );

  // reference: single instructions, chained as the original pairs
  function automatic logic [63:0] r_slli(input logic [63:0] x, input int n); return x << n; endfunction
  function automatic logic [63:0] r_srli(input logic [63:0] x, input int n); return x >> n; endfunction
  function automatic logic [63:0] r_andi(input logic [63:0] x, input logic [11:0] imm);
    return x & {{52{imm[11]}}, imm};
  endfunction
  function automatic logic [63:0] r_addw(input logic [63:0] x, input logic [63:0] y);
    logic [31:0] s;
    s = x[31:0] + y[31:0];
    return {{32{s[31]}}, s};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [5:0] c, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] exp);
    @(negedge clk);
    op = c; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check(req, out_result, exp);
  endtask

  task automatic t_reset();
    check("R12 reset valid", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_standard();
    for (int i = 0; i < 6; i++) for (int j = 0; j < 6; j++) begin
      logic [63:0] a, b;
      a = vals[i]; b = vals[j];
      run_op("R1 add", 6'd0, a, b, a + b);
      run_op("R1 sub", 6'd1, a, b, a - b);
      run_op("R1 sll", 6'd2, a, b, a << b[5:0]);
      run_op("R1 srl", 6'd3, a, b, a >> b[5:0]);
      run_op("R1 sra", 6'd4, a, b, $signed(a) >>> b[5:0]);
      run_op("R1 and", 6'd5, a, b, a & b);
      run_op("R1 or",  6'd6, a, b, a | b);
      run_op("R1 xor", 6'd7, a, b, a ^ b);
      run_op("R1 sh1add", 6'd8,  a, b, r_slli(a, 1) + b);
      run_op("R1 sh2add", 6'd9,  a, b, r_slli(a, 2) + b);
      run_op("R1 sh3add", 6'd10, a, b, r_slli(a, 3) + b);
    end
  endtask

  task automatic t_zwshl();
    for (int i = 0; i < 6; i++) for (int k = 1; k <= 3; k++)
      run_op("R2 zext-shift", 6'(23 + k), vals[i], vals[5 - i],
             r_srli(r_slli(vals[i], 32), 32 - k));
  endtask

  task automatic t_byte();
    for (int i = 0; i < 6; i++)
      run_op("R3 byte", 6'd27, vals[i], vals[i], r_andi(r_srli(vals[i], 8), 12'd255));
  endtask

  task automatic t_sh4add();
    for (int i = 0; i < 6; i++) for (int j = 0; j < 6; j++)
      run_op("R4 sh4add", 6'd16, vals[i], vals[j], r_slli(vals[i], 4) + vals[j]);
  endtask

  task automatic t_sradd();
    for (int i = 0; i < 6; i++) for (int j = 0; j < 6; j++) for (int n = 29; n <= 32; n++)
      run_op("R5 srNadd", 6'(n - 12), vals[i], vals[j], r_srli(vals[i], n) + vals[j]);
  endtask

  task automatic t_odd();
    for (int i = 0; i < 6; i++) for (int j = 0; j < 6; j++) begin
      run_op("R6 oddadd",  6'd21, vals[i], vals[j], r_andi(vals[i], 12'd1) + vals[j]);
      run_op("R6 oddaddw", 6'd22, vals[i], vals[j], r_addw(r_andi(vals[i], 12'd1), vals[j]));
    end
  endtask

  task automatic t_addw_narrow();
    for (int i = 0; i < 6; i++) for (int j = 0; j < 6; j++) begin
      run_op("R7 addw byte", 6'd32, vals[i], vals[j], r_andi(r_addw(vals[i], vals[j]), 12'd255));
      run_op("R7 addw bit",  6'd33, vals[i], vals[j], r_andi(r_addw(vals[i], vals[j]), 12'd1));
    end
  endtask

  task automatic t_logic_lsb();
    for (int i = 0; i < 6; i++) for (int j = 0; j < 6; j++) begin
      logic [63:0] a, b;
      a = vals[i]; b = vals[j];
      run_op("R8 and lsb",  6'd40, a, b, r_andi(a & b, 12'd1));
      run_op("R8 or lsb",   6'd41, a, b, r_andi(a | b, 12'd1));
      run_op("R8 xor lsb",  6'd42, a, b, r_andi(a ^ b, 12'd1));
      run_op("R8 andn lsb", 6'd43, a, b, r_andi(a & ~b, 12'd1));
      run_op("R8 orn lsb",  6'd44, a, b, r_andi(a | ~b, 12'd1));
      run_op("R8 xnor lsb", 6'd45, a, b, r_andi(~(a ^ b), 12'd1));
    end
  endtask

  task automatic t_orhi();
    for (int i = 0; i < 6; i++) for (int j = 0; j < 6; j++)
      run_op("R9 masked or", 6'd28, vals[i], vals[j], r_andi(vals[i], 12'hF00) | vals[j]);
  endtask

  task automatic t_undefined();
    logic [5:0] bad [8] = '{6'd11, 6'd15, 6'd23, 6'd29, 6'd34, 6'd39, 6'd46, 6'd63};
    for (int i = 0; i < 8; i++)
      run_op("R10 undefined", bad[i], 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'd0);
  endtask

  task automatic t_reset_collide();
    run_op("R11 pre-collide", 6'd0, 64'd1, 64'd1, 64'd2);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; op = 6'd0; src_a = 64'd5; src_b = 64'd7;
    @(negedge clk);
    check("R12 valid cleared", {63'd0, out_valid}, 64'd0);
    check("R12 result loaded", out_result, 64'd12);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R11 idle valid", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_hold();
    run_op("R11 latency", 6'd8, 64'd3, 64'd4, 64'd10);
    @(negedge clk);
    in_valid = 1'b0; op = 6'd0; src_a = 64'hAAAA; src_b = 64'h5555;
    @(negedge clk);
    check("R13 held result", out_result, 64'd10);
    check("R11 valid low", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R13 held again", out_result, 64'd10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    vals[0] = 64'd0;
    vals[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    vals[2] = 64'h0000_0000_8000_0000;
    vals[3] = 64'h0000_0000_7FFF_FFFF;
    vals[4] = {$urandom(7), $urandom};
    vals[5] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_standard();
    t_zwshl();
    t_byte();
    t_sh4add();
    t_sradd();
    t_odd();
    t_addw_narrow();
    t_logic_lsb();
    t_orhi();
    t_undefined();
    t_reset_collide();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule